// File: doc/BRIEF.md
# Least-Recently-Served Matrix Arbiter

This block picks one winner among a small set of requesters (four by default). It keeps a pairwise priority relation between every two requesters. Only the upper triangle of that relation is held in flip-flops. The relation in the other direction is the inverse of the stored bit. A requester wins in the current cycle when it is requesting and no active requester has priority over it. The grant is combinational, so it changes in the same cycle as the request vector.

The consumer of the grant raises an accept strobe when it takes the winner. On that clock edge the winner drops below every other requester. The relative order of all the other requesters stays as it was. The result is a least-recently-served order: a requester that holds its request is served after at most N-1 grants to others.

A typical use is at a shared resource. The grant is held while the resource is busy, and the strobe is pulsed when the transfer completes.

Top module: `lrs_matrix_arbiter`

## Requirements
- R1: After reset every stored priority bit is 1. Each lower-index requester therefore has priority over each higher-index requester, and the order is 0,1,2,...,N-1.
- R2: At most one bit of grantVec is high at any time. A grant bit is high only when the matching bit of reqVec is high.
- R3: grantValid is high in a cycle exactly when at least one bit of reqVec is high in that same cycle.
- R4: The input granted is the requesting input that comes first in the current priority order. No active requester has priority over it.
- R5: At a rising edge with acceptStb high and a grant given, the winner moves to the bottom of the order. The other requesters keep their relative order, and the new order applies from the next cycle.
- R6: The order does not change on an edge where acceptStb is low. It also does not change on an edge where acceptStb is high but no request is active.
- R7: A requester that keeps its request high is granted before more than N-1 accepted grants go to other requesters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reqVec | input | NUM_REQ | One request bit per requester |
| acceptStb | input | 1 | The current grant is taken at this edge |
| grantVec | output | NUM_REQ | One-hot (or zero) grant |
| grantValid | output | 1 | A grant is being offered |

## Verification
The bench steers the arbiter into orders reached only after several uneven accepts. It then checks that the grant follows the updated order. A design that swapped the stored bit with its inverse for the lower triangle would grant the wrong requester once the order stops being the reset order.

The bench also pulses the strobe with no requests active, and holds requests with the strobe low. A design that updated on those edges would reorder the queue, and the next grant would differ from the model.

Long runs with every requester held active check the bound on waiting. An update that only cleared the winner's row, without setting its column, would let one requester starve.

// File: rtl/lrs_arb_pkg.sv
package lrs_arb_pkg;
  typedef struct packed {
    logic commit;
    logic idle;
  } arbStb_t;
endpackage

// File: rtl/lrs_arb_ctrl.sv
module lrs_arb_ctrl
  import lrs_arb_pkg::*;
(
  input  logic    acceptStb,
  input  logic    anyGrant,
  output arbStb_t stb
);
  always_comb begin
    stb.commit = acceptStb & anyGrant;
    stb.idle   = ~(acceptStb & anyGrant);
  end
endmodule

// File: rtl/lrs_arb_matrix.sv
module lrs_arb_matrix
  import lrs_arb_pkg::*;
#(
  parameter int NUM_REQ = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] reqVec,
  input  arbStb_t            stb,
  output logic [NUM_REQ-1:0] grantVec,
  output logic               anyGrant
);
  localparam int PAIRS = NUM_REQ * (NUM_REQ - 1) / 2;

  function automatic int pairIdx(input int hi, input int lo);
    return hi * NUM_REQ - (hi * (hi + 1)) / 2 + (lo - hi - 1);
  endfunction

  logic [PAIRS-1:0]   pairBits;
  logic [PAIRS-1:0]   pairNext;
  logic [NUM_REQ-1:0] overMe [NUM_REQ];

  always_comb begin
    for (int i = 0; i < NUM_REQ; i++) begin
      for (int j = 0; j < NUM_REQ; j++) begin
        if (j < i)      overMe[i][j] = pairBits[pairIdx(j, i)];
        else if (j > i) overMe[i][j] = ~pairBits[pairIdx(i, j)];
        else            overMe[i][j] = 1'b0;
      end
    end
    for (int i = 0; i < NUM_REQ; i++)
      grantVec[i] = reqVec[i] & ~|(reqVec & overMe[i]);
    anyGrant = |grantVec;
  end

  always_comb begin
    pairNext = pairBits;
    for (int i = 0; i < NUM_REQ; i++) begin
      for (int j = i + 1; j < NUM_REQ; j++) begin
        if (grantVec[i])      pairNext[pairIdx(i, j)] = 1'b0;
        else if (grantVec[j]) pairNext[pairIdx(i, j)] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           pairBits <= '1;
    else if (stb.commit)  pairBits <= pairNext;
  end

  a_r2_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grantVec));

  a_r6_order_held: assert property (@(posedge clk) disable iff (!rst_n)
    stb.idle |=> $stable(pairBits));

  for (genvar gi = 0; gi < NUM_REQ; gi++) begin : g_row
    for (genvar gj = gi + 1; gj < NUM_REQ; gj++) begin : g_col
      a_r5_row_winner_drops: assert property (@(posedge clk) disable iff (!rst_n)
        stb.commit && grantVec[gi] |=> !pairBits[pairIdx(gi, gj)]);
      a_r5_col_winner_drops: assert property (@(posedge clk) disable iff (!rst_n)
        stb.commit && grantVec[gj] |=> pairBits[pairIdx(gi, gj)]);
    end
  end
endmodule

// File: rtl/lrs_matrix_arbiter.sv
module lrs_matrix_arbiter
  import lrs_arb_pkg::*;
#(
  parameter int NUM_REQ = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] reqVec,
  input  logic               acceptStb,
  output logic [NUM_REQ-1:0] grantVec,
  output logic               grantValid
);
  arbStb_t stb;
  logic    anyGrant;

  lrs_arb_ctrl ctrl_i (
    .acceptStb (acceptStb),
    .anyGrant  (anyGrant),
    .stb       (stb)
  );

  lrs_arb_matrix #(.NUM_REQ(NUM_REQ)) matrix_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqVec   (reqVec),
    .stb      (stb),
    .grantVec (grantVec),
    .anyGrant (anyGrant)
  );

  assign grantValid = anyGrant;

  a_r3_valid_tracks_req: assert property (@(posedge clk) disable iff (!rst_n)
    grantValid == (|reqVec));

  a_r2_grant_in_req: assert property (@(posedge clk) disable iff (!rst_n)
    (grantVec & ~reqVec) == '0);
endmodule

// File: tb/lrs_matrix_arbiter_tb_top.sv
module lrs_matrix_arbiter_tb_top;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] reqVec = '0;
  logic         acceptStb = 1'b0;
  logic [N-1:0] grantVec;
  logic         grantValid;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int orderQ[$];
  int waitCnt [N];

  always #2.5 clk = ~clk;

  lrs_matrix_arbiter #(.NUM_REQ(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .reqVec(reqVec), .acceptStb(acceptStb),
    .grantVec(grantVec), .grantValid(grantValid)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] modelGrant(input logic [N-1:0] r);
    foreach (orderQ[k]) if (r[orderQ[k]]) return N'(1) << orderQ[k];
    return '0;
  endfunction

  task automatic step(input logic [N-1:0] r, input logic acc);
    logic [N-1:0] g;
    int w;
    @(negedge clk);
    reqVec = r;
    acceptStb = acc;
    #1;
    g = modelGrant(r);
    check("R4 grant order", grantVec, g);
    check("R2 grant within req", grantVec & ~r, '0);
    check("R3 valid flag", grantValid, |r);
    @(posedge clk);
    if (acc && g != '0) begin
      w = $clog2(g);
      for (int i = 0; i < N; i++) begin
        if (i == w || !r[i]) waitCnt[i] = 0;
        else begin
          waitCnt[i]++;
          check("R7 wait bound", waitCnt[i] <= N - 1, 1);
        end
      end
      foreach (orderQ[k]) if (orderQ[k] == w) begin orderQ.delete(k); break; end
      orderQ.push_back(w);
    end else begin
      for (int i = 0; i < N; i++) if (!r[i]) waitCnt[i] = 0;
    end
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin orderQ.push_back(i); waitCnt[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1: reset order, input 0 first, then 1 when 0 absent
    check("R1 reset grant none", grantVec, '0);
    reqVec = '1; #1;
    check("R1 reset all req", grantVec, 4'b0001);
    reqVec = 4'b1110; #1;
    check("R1 reset order", grantVec, 4'b0010);
    // R5: round robin with all requesting
    for (int c = 0; c < 10; c++) step('1, 1'b1);
    // R6: requests held, no accept
    for (int c = 0; c < 4; c++) step(4'b1011, 1'b0);
    // R6: accept with nothing requested
    for (int c = 0; c < 3; c++) step('0, 1'b1);
    step('1, 1'b0);
    // R5: uneven accepts to build a non-trivial order
    step(4'b1000, 1'b1);
    step(4'b0100, 1'b1);
    step(4'b1001, 1'b1);
    step(4'b0110, 1'b1);
    step('1, 1'b0);
    // Mixed random traffic, R7 bound tracked continuously
    for (int c = 0; c < 3000; c++) step(N'($urandom), 1'($urandom));
    for (int c = 0; c < 200; c++) step('1, 1'($urandom));
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule